// File: doc/BRIEF.md
# (1,7) RLL Read Decoder with Preamble Lock

This block is the read half of a disk-channel code converter. It takes the already synchronised serial code stream and its code-rate clock, samples a bit on every falling edge, and keeps the most recent nine code bits in a sliding window. It does not decode from the first bit it sees. It first hunts for the 3T preamble, which is a run of `100` code groups. Once it has counted sixteen unbroken preamble pulses it locks. The group framing then follows the phase of the preamble pulses.

After lock, every three code bits form one group. Each group becomes an NRZ pair (MSB, LSB). The decoder looks at the group itself, the group before it and the group after it, because the code uses two-group substitutions that cannot be resolved from one group alone. Each decoded pair is held on two parallel outputs, and a read strobe marks it once per group, so the pair rate is half the NRZ bit rate. The read gate enables the block. Dropping the read gate clears all state, so the next read needs a new preamble.

Top module: `rll17_read_dec`

## Requirements
- R1: `code_in` is sampled on the falling edge of `code_clk`. The bits of each group arrive first-bit-first, and the decode window holds three whole groups with the oldest bit at window index 8.
- R2: With `rd_gate` high, the block locks when it has seen sixteen pulses in which each `1` follows the previous `1` after exactly two `0`s. `rd_clk` first goes high after the fourth falling edge that follows the edge that sampled the sixteenth pulse, and never before.
- R3: A gap of three or more `0`s before the sixteenth pulse clears the pulse count, so sixteen fresh pulses are needed after the break.
- R4: While `rst_n` is low, and from the first falling edge at which `rd_gate` is sampled low, `nrz_msb`, `nrz_lsb` and `rd_clk` are 0 and all state is cleared. Code bits seen while the gate is low are ignored.
- R5: A group starts on each preamble pulse bit and repeats every three code clocks. `rd_clk` is high for one code clock out of every three. The pair changes one code clock before `rd_clk` rises and holds while it is high.
- R6: When the next group is not `000`, the current group decodes as `101`→00, `100`→01, `001`→10, `010`→11 (pair written MSB,LSB). Preamble groups therefore yield 01.
- R7: When the next group is `000`, the current group decodes as `101` or `100` → 00, and as `001` or `010` → 10.
- R8: A current group of `000` decodes to 00 if the previous group ended in `1`, and to 01 if it ended in `0`.
- R9: The pair for a group whose first bit is sampled at falling edge n is registered at edge n+6, which is two group periods later. `rd_clk` is high after edge n+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code_clk | input | 1 | Code-rate clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_gate | input | 1 | Read enable; low clears the block |
| code_in | input | 1 | Synchronised serial code bit |
| nrz_msb | output | 1 | Decoded NRZ MSB |
| nrz_lsb | output | 1 | Decoded NRZ LSB |
| rd_clk | output | 1 | One-in-three strobe marking a valid pair |

## Verification
Two pairs of events share a single falling edge. The first pair is the lock and group framing: the edge that counts the sixteenth pulse also sets the group phase. The bench provokes this with preambles of 16 and of 20 pulses, and with a run that comes right after a broken one. It then checks that the first strobe lands at exactly the bit index the rules predict. The second pair is a read-gate drop and the end of a group: the gate is pulled low on the edge after the last expected strobe. The bench then checks that no further strobe appears, that both pair outputs return to zero, and that a full preamble sent while the gate is low produces nothing. The scoreboard also covers every substitution case, with both kinds of previous-group ending.

// File: rtl/rll17_pkg.sv
package rll17_pkg;

    localparam int GRP_BITS = 3;
    localparam int WIN_BITS = 3 * GRP_BITS;
    localparam int PH_W     = $clog2(GRP_BITS);

    // Window layout: [8:6] previous group, [5:3] current, [2:0] next.
    // Within a group the first-sampled bit sits at the higher index.
    function automatic logic [1:0] rll17_decode(input logic [WIN_BITS-1:0] w);
        logic [1:0] p;
        if (w[5:3] == 3'b000)
            p = {1'b0, ~w[6]};          // second half of a substitution
        else if (w[2:0] == 3'b000)
            p = {~w[5], 1'b0};          // first half of a substitution
        else
            p = {~w[5], ~w[3]};         // plain group
        return p;
    endfunction

    typedef struct packed {
        logic [PH_W-1:0] phase;
        logic            primed;
        logic [1:0]      pair;
    } grp_st_t;

endpackage

// File: rtl/rll17_window.sv
module rll17_window
    import rll17_pkg::*;
#(
    parameter int WIDTH = WIN_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic             din,
    output logic [WIDTH-1:0] win
);

    logic [WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (!gate)
            sr_d = '0;
        else
            sr_d = {sr_q[WIDTH-2:0], din};
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign win = sr_q;

endmodule

// File: rtl/rll17_preamble_det.sv
module rll17_preamble_det #(
    parameter int PULSES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    input  logic din,
    output logic found,
    output logic lock_now
);

    localparam int CW = $clog2(PULSES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    gap;     // zeros since last one, saturating at 3
        logic          found;
    } pre_st_t;

    localparam pre_st_t PRE_RST = '{cnt: '0, gap: 2'd3, found: 1'b0};

    pre_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        lock_now = 1'b0;
        if (!gate) begin
            s_d = PRE_RST;
        end else if (!s_q.found) begin
            if (din) begin
                s_d.gap = 2'd0;
                s_d.cnt = (s_q.gap == 2'd2) ? s_q.cnt + 1'b1 : CW'(1);
                if (s_d.cnt == CW'(PULSES)) begin
                    s_d.found = 1'b1;
                    lock_now  = 1'b1;
                end
            end else begin
                if (s_q.gap != 2'd3) s_d.gap = s_q.gap + 2'd1;
                if (s_q.gap == 2'd2) s_d.cnt = '0;
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= PRE_RST;
        else        s_q <= s_d;
    end

    assign found = s_q.found;

    assert_lock_full_run_R2: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(s_q.found) |-> ((PULSES == 1) || ($past(s_q.cnt) == CW'(PULSES - 1))));

    assert_lock_on_pulse_R2: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(s_q.found) |-> $past(din));

    assert_count_step_R3: assert property (@(negedge clk) disable iff (!rst_n)
        (s_q.cnt > $past(s_q.cnt)) |-> (s_q.cnt == $past(s_q.cnt) + 1'b1));

endmodule

// File: rtl/rll17_group_dec.sv
module rll17_group_dec
    import rll17_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gate,
    input  logic                found,
    input  logic                lock_now,
    input  logic [WIN_BITS-1:0] win,
    output logic                nrz_msb,
    output logic                nrz_lsb,
    output logic                rclk
);

    localparam grp_st_t GRP_RST = '{phase: '0, primed: 1'b0, pair: 2'b00};

    grp_st_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!gate) begin
            g_d = GRP_RST;
        end else if (lock_now) begin
            g_d.phase = PH_W'(1);       // lock bit is first bit of a group
        end else if (found) begin
            g_d.phase = (g_q.phase == PH_W'(GRP_BITS - 1)) ? '0 : g_q.phase + 1'b1;
            if (g_q.phase == '0) begin
                g_d.pair   = rll17_decode(win);
                g_d.primed = 1'b1;
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= GRP_RST;
        else        g_q <= g_d;
    end

    assign nrz_msb = g_q.pair[1];
    assign nrz_lsb = g_q.pair[0];
    assign rclk    = g_q.primed && (g_q.phase == PH_W'(GRP_BITS - 1));

    assert_rclk_single_R5: assert property (@(negedge clk) disable iff (!rst_n)
        rclk |=> !rclk);

    assert_pair_hold_R5: assert property (@(negedge clk) disable iff (!rst_n)
        rclk |-> $stable(g_q.pair));

    assert_no_strobe_unlocked_R2: assert property (@(negedge clk) disable iff (!rst_n)
        !found |-> !rclk);

endmodule

// File: rtl/rll17_read_dec.sv
module rll17_read_dec
    import rll17_pkg::*;
#(
    parameter int PRE_PULSES = 16
) (
    input  logic code_clk,
    input  logic rst_n,
    input  logic rd_gate,
    input  logic code_in,
    output logic nrz_msb,
    output logic nrz_lsb,
    output logic rd_clk
);

    logic [WIN_BITS-1:0] win;
    logic                found;
    logic                lock_now;

    rll17_window #(.WIDTH(WIN_BITS)) u_window (
        .clk   (code_clk),
        .rst_n (rst_n),
        .gate  (rd_gate),
        .din   (code_in),
        .win   (win)
    );

    rll17_preamble_det #(.PULSES(PRE_PULSES)) u_pre (
        .clk      (code_clk),
        .rst_n    (rst_n),
        .gate     (rd_gate),
        .din      (code_in),
        .found    (found),
        .lock_now (lock_now)
    );

    rll17_group_dec u_grp (
        .clk      (code_clk),
        .rst_n    (rst_n),
        .gate     (rd_gate),
        .found    (found),
        .lock_now (lock_now),
        .win      (win),
        .nrz_msb  (nrz_msb),
        .nrz_lsb  (nrz_lsb),
        .rclk     (rd_clk)
    );

    assert_gate_clears_R4: assert property (@(negedge code_clk) disable iff (!rst_n)
        !rd_gate |=> (!rd_clk && !nrz_msb && !nrz_lsb));

endmodule

// File: tb/rll17_read_dec_tb.sv
module rll17_read_dec_tb;

    localparam int CLK_NS = 20;
    localparam int PRE    = 16;

    logic code_clk = 1'b0;
    logic rst_n    = 1'b0;
    logic rd_gate  = 1'b0;
    logic code_in  = 1'b0;
    logic nrz_msb, nrz_lsb, rd_clk;

    int checks  = 0;
    int fails   = 0;
    int bit_idx = -1;
    bit done    = 1'b0;

    typedef struct {
        logic [1:0] pair;
        int         idx;
        string      req;
        string      idx_req;
    } exp_t;

    exp_t       exp_q[$];
    logic [1:0] data_q[$];

    always #(CLK_NS/2) code_clk = ~code_clk;

    rll17_read_dec #(.PRE_PULSES(PRE)) u_dut (
        .code_clk (code_clk),
        .rst_n    (rst_n),
        .rd_gate  (rd_gate),
        .code_in  (code_in),
        .nrz_msb  (nrz_msb),
        .nrz_lsb  (nrz_lsb),
        .rd_clk   (rd_clk)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic g);
        @(posedge code_clk);
        code_in = b;
        rd_gate = g;
        bit_idx++;
    endtask

    // Monitor: pops one expected pair per strobe.
    always @(negedge code_clk) begin
        exp_t e;
        #5;
        if (rst_n && rd_clk) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected rd_clk strobe", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check({nrz_msb, nrz_lsb} == e.pair, e.req, "decoded pair (R1 bit order)",
                      int'({nrz_msb, nrz_lsb}), int'(e.pair));
                check(bit_idx == e.idx, e.idx_req, "strobe bit index", bit_idx, e.idx);
            end
        end
    end

    task automatic run_frame(input int nbreak, input int lead, input int npre);
        logic [2:0] grp[$];
        logic [1:0] prs[$];
        string      rqs[$];
        logic [1:0] d, nx;
        int         L, i, n;
        L = (nbreak > 0) ? 3 * nbreak + 1 : lead;
        for (int g = 0; g < npre; g++) begin
            grp.push_back(3'b100); prs.push_back(2'b01); rqs.push_back("R6");
        end
        n = data_q.size();
        i = 0;
        while (i < n) begin
            d  = data_q[i];
            nx = (i + 1 < n) ? data_q[i+1] : 2'b11;
            if ((i + 1 < n) && (d == 2'b00 || d == 2'b10) && (nx == 2'b00 || nx == 2'b01)) begin
                case ({d, nx})
                    4'b0000: grp.push_back(3'b101);
                    4'b0001: grp.push_back(3'b100);
                    4'b1000: grp.push_back(3'b001);
                    default: grp.push_back(3'b010);
                endcase
                prs.push_back(d);  rqs.push_back("R7");
                grp.push_back(3'b000);
                prs.push_back(nx); rqs.push_back("R8");
                i += 2;
            end else begin
                case (d)
                    2'b00:   grp.push_back(3'b101);
                    2'b01:   grp.push_back(3'b100);
                    2'b10:   grp.push_back(3'b001);
                    default: grp.push_back(3'b010);
                endcase
                prs.push_back(d); rqs.push_back("R6");
                i++;
            end
        end
        grp.push_back(3'b010); prs.push_back(2'b11); rqs.push_back("R6"); // pad
        for (int g = PRE - 2; g < int'(grp.size()) - 1; g++)
            exp_q.push_back('{prs[g], L + 3 * g + 7, rqs[g],
                              (g == PRE - 2) ? ((nbreak > 0) ? "R3" : "R2") : "R9"});
        bit_idx = -1;
        if (nbreak > 0) begin
            for (int p = 0; p < nbreak; p++) begin
                send_bit(1'b1, 1'b1); send_bit(1'b0, 1'b1); send_bit(1'b0, 1'b1);
            end
            send_bit(1'b0, 1'b1);
            @(negedge code_clk); #5;
            check(!rd_clk, "R3", "no strobe after broken run", int'(rd_clk), 0);
        end else begin
            for (int z = 0; z < lead; z++) send_bit(1'b0, 1'b1);
        end
        foreach (grp[k]) begin
            send_bit(grp[k][2], 1'b1);
            send_bit(grp[k][1], 1'b1);
            send_bit(grp[k][0], 1'b1);
        end
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b1);
        @(posedge code_clk);
        rd_gate = 1'b0;
        code_in = 1'b0;
        @(negedge code_clk); #5;
        check(exp_q.size() == 0, "R5", "pending expected pairs", exp_q.size(), 0);
        check({nrz_msb, nrz_lsb, rd_clk} == 3'b000, "R4", "outputs after gate drop",
              int'({nrz_msb, nrz_lsb, rd_clk}), 0);
        exp_q.delete();
        data_q.delete();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge code_clk);
        @(negedge code_clk); #5;
        check({nrz_msb, nrz_lsb, rd_clk} == 3'b000, "R4", "outputs in reset",
              int'({nrz_msb, nrz_lsb, rd_clk}), 0);
        @(posedge code_clk);
        rst_n = 1'b1;

        // Run A: all plain groups and every substitution form.
        data_q = '{2'b11, 2'b01, 2'b11, 2'b00, 2'b11, 2'b10, 2'b10, 2'b11, 2'b00,
                   2'b00, 2'b00, 2'b01, 2'b10, 2'b00, 2'b10, 2'b01, 2'b01, 2'b11};
        run_frame(0, 2, 16);

        // Gate low: a full preamble plus data must be ignored.
        for (int p = 0; p < 20; p++) begin
            send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
        end
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
        @(negedge code_clk); #5;
        check({nrz_msb, nrz_lsb, rd_clk} == 3'b000, "R4", "outputs with gate low",
              int'({nrz_msb, nrz_lsb, rd_clk}), 0);

        // Run B: fifteen pulses, a break, then a fresh run.
        data_q = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01, 2'b00, 2'b10};
        run_frame(15, 0, 16);

        // Run C: long preamble, no lead-in.
        data_q = '{2'b11, 2'b11, 2'b00, 2'b11, 2'b10, 2'b00};
        run_frame(0, 0, 20);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule